// File: doc/BRIEF.md
# Eight-Bit Accumulator-Memory ALU

This block is the arithmetic and logic core of a small accumulator machine. Each cycle it takes a 4-bit operation code and two byte-wide operands. One operand comes from the accumulator and the other from the memory side. It produces a byte result and a single status flag.

The flag means different things for different groups of operations:
- For the logic group it reports a zero result.
- For the rotate group it copies the top bit of the rotated value.
- For the arithmetic group it is the carry out of the top bit.

Rotates, complements and increments can each act on either operand. Choosing where the result goes, fetching the operands and sequencing are the surrounding machine's job.

The outputs are registered by default. A result appears one clock after its inputs are sampled. Setting `REG_OUT` to 0 turns the block into pure combinational logic.

Top module: `acc_mem_alu`

## Requirements
- R1: Opcode 0 passes `acc` and opcode 1 passes `mem` to the result. `flag` is 1 exactly when the result is zero.
- R2: Opcode 2 gives `acc ^ mem`, opcode 6 gives `acc & mem` and opcode 7 gives `acc | mem`. `flag` is 1 exactly when the result is zero.
- R3: Opcode 3 gives result 0 and always sets `flag` to 1, whatever the operands.
- R4: Opcode 4 gives `~acc` and opcode 5 gives `~mem`. `flag` is 1 exactly when the result is zero.
- R5: The rotate opcodes are plain 8-bit rotates that do not pass through the flag:
  - Opcode 8 rotates `acc` left by one.
  - Opcode 9 rotates `acc` right by one.
  - Opcode 10 rotates `mem` left by one.
  - Opcode 11 rotates `mem` right by one.
  
  For all four, `flag` equals bit 7 of the rotated result.
- R6: Opcode 12 gives the low byte of `acc + mem`, and `flag` is the carry out of bit 7.
- R7: Opcode 13 gives `acc + 1` and opcode 14 gives `mem + 1`, each keeping the low byte. `flag` is the carry out of bit 7, so incrementing 0xFF gives 0x00 with `flag` = 1.
- R8: Opcode 15 is unused and gives result 0 with `flag` = 0.
- R9: With `REG_OUT` = 1, the result and flag for the inputs sampled at one rising edge of `clk` appear after that edge. While `rst_n` is low, `res` and `flag` are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator operand |
| mem | input | 8 | Memory operand |
| res | output | 8 | Result byte |
| flag | output | 1 | Zero, top-bit or carry flag, depending on the opcode |

## Verification
The bench aims at the places where the flag changes meaning:
- Clear must set the flag even when both operands are zero or all ones. A design that tested zero on the wrong signal would miss this.
- Rotates of 0x80 and 0x01 show whether the wrap bit lands at the correct end and whether the flag follows the result's top bit rather than the operand's.
- Incrementing and adding across 0xFF shows whether the carry is taken from bit 8 of the sum.
- Opcode 15 shows whether the unused code leaks an operand or a stale flag.

Operand swaps (acc against mem) on the single-operand opcodes catch a design that reads the wrong source. The reset check catches an output stage that does not clear.

// File: rtl/acc_mem_alu.sv
module acc_mem_alu #(
  parameter int W = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mem,
  output logic [W-1:0] res,
  output logic         flag
);

  logic [W:0]   sum;
  logic [W-1:0] r_d;
  logic         f_d;

  always_comb begin
    sum = '0;
    r_d = '0;
    f_d = 1'b0;
    case (op)
      4'h0: r_d = acc;
      4'h1: r_d = mem;
      4'h2: r_d = acc ^ mem;
      4'h3: r_d = '0;
      4'h4: r_d = ~acc;
      4'h5: r_d = ~mem;
      4'h6: r_d = acc & mem;
      4'h7: r_d = acc | mem;
      4'h8: r_d = {acc[W-2:0], acc[W-1]};
      4'h9: r_d = {acc[0], acc[W-1:1]};
      4'hA: r_d = {mem[W-2:0], mem[W-1]};
      4'hB: r_d = {mem[0], mem[W-1:1]};
      4'hC: sum = {1'b0, acc} + {1'b0, mem};
      4'hD: sum = {1'b0, acc} + 1'b1;
      4'hE: sum = {1'b0, mem} + 1'b1;
      default: r_d = '0;
    endcase
    if (op[3:2] == 2'b11 && op != 4'hF) begin
      r_d = sum[W-1:0];
      f_d = sum[W];
    end else if (op[3:2] == 2'b10) begin
      f_d = r_d[W-1];
    end else if (!op[3]) begin
      f_d = (r_d == '0);
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          res  <= '0;
          flag <= 1'b0;
        end else begin
          res  <= r_d;
          flag <= f_d;
        end
      end
    end else begin : g_comb
      assign res  = r_d;
      assign flag = f_d;
    end
  endgenerate

endmodule

module alu_props #(
  parameter int W = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op,
  input logic [W-1:0] acc,
  input logic [W-1:0] mem,
  input logic [W-1:0] res,
  input logic         flag
);

  logic [3:0]   q_op;
  logic [W-1:0] q_acc, q_mem;
  logic         primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_op <= '0; q_acc <= '0; q_mem <= '0; primed <= 1'b0;
    end else begin
      q_op <= op; q_acc <= acc; q_mem <= mem; primed <= 1'b1;
    end
  end

  wire [3:0]   s_op  = REG_OUT ? q_op  : op;
  wire [W-1:0] s_acc = REG_OUT ? q_acc : acc;
  wire [W-1:0] s_mem = REG_OUT ? q_mem : mem;
  wire         chk   = primed || !REG_OUT;

  assert_zero_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && !s_op[3]) |-> (flag == (res == '0)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && s_op == 4'h3) |-> (res == '0 && flag));

  assert_rot_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && s_op[3:2] == 2'b10) |-> (flag == res[W-1]));

  assert_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && s_op == 4'hC) |-> ({flag, res} == ({1'b0, s_acc} + {1'b0, s_mem})));

  assert_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && s_op == 4'hD) |-> ({flag, res} == ({1'b0, s_acc} + 1'b1)));

  assert_unused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && s_op == 4'hF) |-> (res == '0 && !flag));

  assert_reset_R9: assert property (@(posedge clk)
    (REG_OUT && !rst_n) |=> (res == '0 && !flag));

endmodule

bind acc_mem_alu alu_props #(.W(W), .REG_OUT(REG_OUT)) u_props (.*);

// File: tb/sim_acc_mem_alu.sv
`timescale 1ns/1ps
module sim_acc_mem_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] acc = '0, mem = '0;
  logic [7:0] res;
  logic flag;
  int n_chk = 0, n_err = 0;
  int exp_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  acc_mem_alu u0 (.clk(clk), .rst_n(rst_n), .op(op), .acc(acc), .mem(mem), .res(res), .flag(flag));

  function automatic int model(int o, int a, int m);
    int r, f;
    f = 0;
    case (o)
      0: r = a;
      1: r = m;
      2: r = a ^ m;
      3: r = 0;
      4: r = 255 - a;
      5: r = 255 - m;
      6: r = a & m;
      7: r = a | m;
      8: r = ((a * 2) % 256) + a / 128;
      9: r = a / 2 + (a % 2) * 128;
      10: r = ((m * 2) % 256) + m / 128;
      11: r = m / 2 + (m % 2) * 128;
      12: r = a + m;
      13: r = a + 1;
      14: r = m + 1;
      default: r = 0;
    endcase
    if (o < 8) f = (r == 0);
    else if (o < 12) f = r / 128;
    else if (o < 15) begin f = r / 256; r = r % 256; end
    return r * 2 + f;
  endfunction

  function automatic string req_of(int o);
    if (o == 0 || o == 1) return "R1";
    if (o == 2 || o == 6 || o == 7) return "R2";
    if (o == 3) return "R3";
    if (o == 4 || o == 5) return "R4";
    if (o >= 8 && o <= 11) return "R5";
    if (o == 12) return "R6";
    if (o == 13 || o == 14) return "R7";
    return "R8";
  endfunction

  task automatic apply(int o, int a, int m);
    int e;
    int so;
    @(negedge clk);
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      so = e / 1024;
      n_chk++;
      if ({res, flag} != 9'((e % 1024))) begin
        n_err++;
        $display("FAIL %s op=%0d actual res=%02h flag=%0d expected res=%02h flag=%0d",
                 req_of(so), so, res, flag, (e % 1024) / 2, e % 2);
      end
    end
    op = 4'(o); acc = 8'(a); mem = 8'(m);
    exp_q.push_back(o * 1024 + model(o, a, m));
  endtask

  initial begin
    op = 4'h7; acc = 8'hA5; mem = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (res !== 8'h00 || flag !== 1'b0) begin
      n_err++;
      $display("FAIL R9 reset actual res=%02h flag=%0d expected res=00 flag=0", res, flag);
    end
    rst_n = 1'b1;
    apply(0, 8'h00, 8'h33);  apply(0, 8'h42, 8'h00);
    apply(1, 8'h42, 8'h00);  apply(1, 8'h00, 8'h81);
    apply(2, 8'h3C, 8'h3C);  apply(2, 8'hF0, 8'h0F);
    apply(6, 8'hF0, 8'h0F);  apply(6, 8'hFF, 8'h81);
    apply(7, 8'h00, 8'h00);  apply(7, 8'h10, 8'h01);
    apply(3, 8'h00, 8'h00);  apply(3, 8'hFF, 8'hFF);
    apply(4, 8'hFF, 8'h00);  apply(4, 8'h00, 8'hFF);
    apply(5, 8'h00, 8'hFF);  apply(5, 8'hFF, 8'h12);
    apply(8, 8'h80, 8'h00);  apply(8, 8'h40, 8'h00);
    apply(9, 8'h01, 8'hFF);  apply(9, 8'h80, 8'h00);
    apply(10, 8'h00, 8'hC0); apply(10, 8'hFF, 8'h01);
    apply(11, 8'h00, 8'h01); apply(11, 8'hFF, 8'h02);
    apply(12, 8'h80, 8'h80); apply(12, 8'h7F, 8'h01); apply(12, 8'hFF, 8'h01);
    apply(13, 8'hFF, 8'h00); apply(13, 8'h7F, 8'hFF);
    apply(14, 8'h00, 8'hFF); apply(14, 8'hFF, 8'h10);
    apply(15, 8'hFF, 8'hFF); apply(15, 8'h00, 8'h00);
    for (int i = 0; i < 400; i++) apply($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255));
    apply(0, 0, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule